// File: doc/BRIEF.md
# I2C Target with Transaction Status Flags

This block is a 7-bit-address I2C target that can both receive and send bytes. It works from SCL and SDA levels that have already been synchronised to the system clock. It finds start and stop conditions and compares the first byte of each transfer with its own address. When the address matches it answers with an ACK. For a master read, it holds SCL low until the processor has loaded the next byte.

On the processor side there is one data buffer, an 8-bit status word and a sticky interrupt line. Firmware masks the status word with 0x2D and gets one of five transaction states. The states cover a write address, write data, a read address, a read data byte that was ACKed, and the end of a read by NACK.

A parameter picks one of two flag variants for master-read transfers. The legacy variant leaves buffer-full clear on a read address and drops read/write on a NACK. The newer variant loads the address byte and sets buffer-full, and it keeps read/write set after a NACK.

Top module: `i2c_target_stat`

## Requirements
- R1: After reset the status word is 0x00, `irq` is 0, and neither `sda_oe` nor `scl_oe` is asserted.
- R2: A start condition (SDA falls while SCL is high) sets status bit 3 and clears bit 4. It raises `irq` only when `start_ie` is 1.
- R3: A matching address byte with R/W=0 is ACKed: SDA is low during the ninth clock. After it, status & 0x2D is 0x09, `irq` is 1 and `buf_data` holds the address byte.
- R4: Each data byte of a master write is ACKed while bit 0 was clear. After it, `buf_data` holds the byte, status & 0x2D is 0x29 and `irq` is 1.
- R5: A `cpu_rd` pulse clears status bit 0.
- R6: A matching address with R/W=1 gives status & 0x2D of 0x0C with NEW_FLAGS=0. With NEW_FLAGS=1 it gives 0x0D, and `buf_data` holds the address byte.
- R7: After a read address is ACKed, the block holds SCL low until `cpu_rel` is pulsed. It then sends `buf_data` MSB first on SDA.
- R8: When the master ACKs a sent byte, status & 0x2D is 0x2C, `irq` is 1 and SCL is held low again until `cpu_rel`.
- R9: When the master NACKs a sent byte, status & 0x2D is 0x28 with NEW_FLAGS=0 and 0x2C with NEW_FLAGS=1, and SCL is not held.
- R10: An address byte that does not match is not ACKed. It leaves the status word unchanged and does not raise `irq`.
- R11: A stop condition (SDA rises while SCL is high) clears status bit 3 and sets bit 4.
- R12: A data byte that arrives while status bit 0 is set is not ACKed. It sets status bit 6 and leaves `buf_data` unchanged.
- R13: `irq` stays set until a `cpu_irq_clr` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| own_addr | input | 7 | Address this target answers to |
| start_ie | input | 1 | Raise irq on start conditions |
| cpu_rd | input | 1 | Pulse: the processor has read the buffer |
| cpu_wr | input | 1 | Pulse: load cpu_wdata into the buffer |
| cpu_wdata | input | 8 | Byte to load |
| cpu_rel | input | 1 | Pulse: release the held SCL |
| cpu_irq_clr | input | 1 | Pulse: clear irq |
| buf_data | output | 8 | Data buffer contents |
| status | output | 8 | Bit0 full, bit2 read, bit3 start, bit4 stop, bit5 data, bit6 overflow |
| irq | output | 1 | Sticky interrupt flag |
| sda_oe | output | 1 | Pull SDA low |
| scl_oe | output | 1 | Pull SCL low |

## Verification
The hardest states to reach are the ones that exist only while the target itself holds SCL. At those points the master model cannot move on, and the processor side must load a byte and release the clock at the right time. The bench puts a legacy target and a newer target on one shared bus, each with its own address. The master model waits on the wired-AND of SCL, so it stalls exactly when a target holds the clock. Between bytes, the bench acts as the processor: it checks the held clock, loads the next byte and releases SCL. It then reads back the bytes the target sends. The overflow case is reached by leaving the buffer unread after a write address.

// File: rtl/i2c_ts_pkg.sv
package i2c_ts_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam int ST_FULL = 0;
  localparam int ST_RD   = 2;
  localparam int ST_STA  = 3;
  localparam int ST_STO  = 4;
  localparam int ST_DAT  = 5;
  localparam int ST_OVF  = 6;

  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_ACK, L_RX, L_TX, L_TACK
  } link_st_e;

  typedef struct packed {
    logic sta;
    logic sto;
    logic adr;
    logic rx;
    logic tack;
    logic tnack;
    logic hold;
  } bus_ev_t;
endpackage

// File: rtl/i2c_ts_cond.sv
module i2c_ts_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sta_det,
  output logic sto_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign sta_det  = scl_i & scl_q & sda_q & ~sda_i;
  assign sto_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_ts_link.sv
module i2c_ts_link
  import i2c_ts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sta_det,
  input  logic              sto_det,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              buf_full,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output bus_ev_t           ev,
  output logic              ev_rw,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  link_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] sh_q, sh_d;
  logic ack_q, ack_d, drv_q, drv_d, rd_q, rd_d, mack_q, mack_d;

  assign rx_byte = {sh_q, sda_i};
  assign ev_rw   = sda_i;
  assign sda_oe  = drv_q | ((st_q == L_TX) & ~tx_byte[LAST - cnt_q]);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q;
    ack_d = ack_q; drv_d = drv_q; rd_d = rd_q; mack_d = mack_q;
    ev = '0;
    if (sta_det) begin
      ev.sta = 1'b1; st_d = L_ADDR; cnt_d = '0; drv_d = 1'b0;
    end else if (sto_det) begin
      ev.sto = 1'b1; st_d = L_IDLE; drv_d = 1'b0;
    end else begin
      unique case (st_q)
        L_ADDR: if (scl_rise) begin
          sh_d  = {sh_q[ADDR_W-2:0], sda_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            if (sh_q == own_addr) begin
              ev.adr = 1'b1; rd_d = sda_i; ack_d = 1'b1; st_d = L_ACK;
            end else begin
              st_d = L_IDLE;
            end
          end
        end
        L_ACK: if (scl_fall) begin
          if (cnt_q == '0) begin
            drv_d = ack_q; cnt_d = 1'b1;
          end else begin
            drv_d = 1'b0; cnt_d = '0;
            if (!ack_q)    st_d = L_IDLE;
            else if (rd_q) begin st_d = L_TX; ev.hold = 1'b1; end
            else           st_d = L_RX;
          end
        end
        L_RX: if (scl_rise) begin
          sh_d  = {sh_q[ADDR_W-2:0], sda_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            ev.rx = 1'b1; ack_d = ~buf_full; st_d = L_ACK;
          end
        end
        L_TX: if (scl_fall) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) st_d = L_TACK;
        end
        L_TACK: begin
          if (scl_rise) begin
            mack_d   = ~sda_i;
            ev.tack  = ~sda_i;
            ev.tnack = sda_i;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin st_d = L_TX; ev.hold = 1'b1; end
            else        st_d = L_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= L_IDLE; cnt_q <= '0; sh_q <= '0;
      ack_q <= 1'b0; drv_q <= 1'b0; rd_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d;
      ack_q <= ack_d; drv_q <= drv_d; rd_q <= rd_d; mack_q <= mack_d;
    end
  end
endmodule

// File: rtl/i2c_ts_regs.sv
module i2c_ts_regs
  import i2c_ts_pkg::*;
#(
  parameter bit NEW_FLAGS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic              ev_rw,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              start_ie,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  input  logic              cpu_rel,
  input  logic              cpu_irq_clr,
  output logic [BYTE_W-1:0] buf_q,
  output logic              full_q,
  output logic [BYTE_W-1:0] status,
  output logic              irq_q,
  output logic              hold_q
);
  logic rdadr_full, nack_keep_rd;

  generate
    if (NEW_FLAGS) begin : g_newer
      assign rdadr_full   = 1'b1;
      assign nack_keep_rd = 1'b1;
    end else begin : g_legacy
      assign rdadr_full   = 1'b0;
      assign nack_keep_rd = 1'b0;
    end
  endgenerate

  logic [BYTE_W-1:0] buf_d;
  logic full_d, rd_q, rd_d, sta_q, sta_d, sto_q, sto_d;
  logic dat_q, dat_d, ovf_q, ovf_d, irq_d, hold_d;

  always_comb begin
    buf_d = buf_q; full_d = full_q; rd_d = rd_q; sta_d = sta_q; sto_d = sto_q;
    dat_d = dat_q; ovf_d = ovf_q; irq_d = irq_q; hold_d = hold_q;
    if (cpu_wr)      buf_d  = cpu_wdata;
    if (cpu_rd)      full_d = 1'b0;
    if (cpu_irq_clr) irq_d  = 1'b0;
    if (cpu_rel)     hold_d = 1'b0;
    if (ev.sta) begin
      sta_d = 1'b1; sto_d = 1'b0; ovf_d = 1'b0;
      if (start_ie) irq_d = 1'b1;
    end
    if (ev.sto) begin
      sta_d = 1'b0; sto_d = 1'b1;
    end
    if (ev.adr) begin
      dat_d = 1'b0; rd_d = ev_rw; irq_d = 1'b1;
      if (!ev_rw || rdadr_full) begin
        buf_d = rx_byte; full_d = 1'b1;
      end
    end
    if (ev.rx) begin
      dat_d = 1'b1; irq_d = 1'b1;
      if (full_q) ovf_d = 1'b1;
      else begin
        buf_d = rx_byte; full_d = 1'b1;
      end
    end
    if (ev.tack) begin
      dat_d = 1'b1; irq_d = 1'b1;
    end
    if (ev.tnack) begin
      dat_d = 1'b1; irq_d = 1'b1;
      if (!nack_keep_rd) rd_d = 1'b0;
    end
    if (ev.hold) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0; full_q <= 1'b0; rd_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      dat_q <= 1'b0; ovf_q <= 1'b0; irq_q <= 1'b0; hold_q <= 1'b0;
    end else begin
      buf_q <= buf_d; full_q <= full_d; rd_q <= rd_d; sta_q <= sta_d; sto_q <= sto_d;
      dat_q <= dat_d; ovf_q <= ovf_d; irq_q <= irq_d; hold_q <= hold_d;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_FULL] = full_q;
    status[ST_RD]   = rd_q;
    status[ST_STA]  = sta_q;
    status[ST_STO]  = sto_q;
    status[ST_DAT]  = dat_q;
    status[ST_OVF]  = ovf_q;
  end
endmodule

// File: rtl/i2c_target_stat.sv
module i2c_target_stat
  import i2c_ts_pkg::*;
#(
  parameter bit NEW_FLAGS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              start_ie,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  input  logic              cpu_rel,
  input  logic              cpu_irq_clr,
  output logic [BYTE_W-1:0] buf_data,
  output logic [BYTE_W-1:0] status,
  output logic              irq,
  output logic              sda_oe,
  output logic              scl_oe
);
  logic scl_rise, scl_fall, sta_det, sto_det, full, ev_rw;
  logic [BYTE_W-1:0] rx_byte;
  bus_ev_t ev;

  i2c_ts_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sta_det(sta_det), .sto_det(sto_det)
  );

  i2c_ts_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sta_det(sta_det), .sto_det(sto_det), .sda_i(sda_i), .own_addr(own_addr),
    .buf_full(full), .tx_byte(buf_data), .sda_oe(sda_oe), .ev(ev),
    .ev_rw(ev_rw), .rx_byte(rx_byte)
  );

  i2c_ts_regs #(.NEW_FLAGS(NEW_FLAGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ev_rw(ev_rw), .rx_byte(rx_byte),
    .start_ie(start_ie), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rel(cpu_rel), .cpu_irq_clr(cpu_irq_clr), .buf_q(buf_data), .full_q(full),
    .status(status), .irq_q(irq), .hold_q(scl_oe)
  );
endmodule

// File: rtl/i2c_target_stat_chk.sv
module i2c_target_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       cpu_rd,
  input logic       cpu_rel,
  input logic       cpu_irq_clr,
  input logic [7:0] status,
  input logic       irq,
  input logic       sda_oe,
  input logic       scl_oe
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R11
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && scl_i && $past(scl_i) && sda_i && !$past(sda_i)
    |=> status[4] && !status[3]);

  // R13
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cpu_irq_clr |=> irq);

  // R5
  buf_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && cpu_rd && !(scl_i && !$past(scl_i)) |=> !status[0]);

  // R7
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && scl_i && $past(scl_i) |-> $stable(sda_oe));

  // R8
  clock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe && !cpu_rel |=> scl_oe);
endmodule

bind i2c_target_stat i2c_target_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .cpu_rd(cpu_rd),
  .cpu_rel(cpu_rel), .cpu_irq_clr(cpu_irq_clr), .status(status), .irq(irq),
  .sda_oe(sda_oe), .scl_oe(scl_oe)
);

// File: tb/sim_i2c_target_stat.sv
module sim_i2c_target_stat;
  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic [1:0] c_rd, c_wr, c_rel, c_clr, c_sie;
  logic [7:0] wdat;
  logic [7:0] stat [2];
  logic [7:0] bufd [2];
  logic [1:0] irq, soe, coe;
  wire scl_bus = scl_m & ~coe[0] & ~coe[1];
  wire sda_bus = sda_m & ~soe[0] & ~soe[1];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  i2c_target_stat #(.NEW_FLAGS(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .own_addr(7'h18),
    .start_ie(c_sie[0]), .cpu_rd(c_rd[0]), .cpu_wr(c_wr[0]), .cpu_wdata(wdat),
    .cpu_rel(c_rel[0]), .cpu_irq_clr(c_clr[0]), .buf_data(bufd[0]), .status(stat[0]),
    .irq(irq[0]), .sda_oe(soe[0]), .scl_oe(coe[0])
  );

  i2c_target_stat #(.NEW_FLAGS(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .own_addr(7'h30),
    .start_ie(c_sie[1]), .cpu_rd(c_rd[1]), .cpu_wr(c_wr[1]), .cpu_wdata(wdat),
    .cpu_rel(c_rel[1]), .cpu_irq_clr(c_clr[1]), .buf_data(bufd[1]), .status(stat[1]),
    .irq(irq[1]), .sda_oe(soe[1]), .scl_oe(coe[1])
  );

  typedef struct packed {
    logic       strt;
    logic       sel;
    logic [7:0] tx;
    logic       ack;
    logic [7:0] mst;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 8'h30, 1'b1, 8'h09},
    '{1'b0, 1'b0, 8'h2F, 1'b1, 8'h29},
    '{1'b0, 1'b0, 8'h15, 1'b1, 8'h29},
    '{1'b1, 1'b1, 8'h60, 1'b1, 8'h09},
    '{1'b0, 1'b1, 8'h3A, 1'b1, 8'h29},
    '{1'b0, 1'b1, 8'h2A, 1'b1, 8'h29}
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_pulse();
    scl_m = 1'b1;
    @(negedge clk);
    while (scl_bus == 1'b0) @(negedge clk);
    wait_cyc(5);
    scl_m = 1'b0;
    wait_cyc(5);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wait_cyc(2);
    scl_m = 1'b1; wait_cyc(5);
    sda_m = 1'b0; wait_cyc(5);
    scl_m = 1'b0; wait_cyc(5);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wait_cyc(3);
    scl_m = 1'b1; wait_cyc(5);
    sda_m = 1'b1; wait_cyc(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_seen);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_cyc(2);
      scl_pulse();
    end
    sda_m = 1'b1; wait_cyc(2);
    scl_m = 1'b1;
    @(negedge clk);
    while (scl_bus == 1'b0) @(negedge clk);
    wait_cyc(2);
    ack_seen = ~sda_bus;
    wait_cyc(3);
    scl_m = 1'b0;
    wait_cyc(5);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_cyc(2);
      scl_m = 1'b1;
      @(negedge clk);
      while (scl_bus == 1'b0) @(negedge clk);
      wait_cyc(2);
      b[i] = sda_bus;
      wait_cyc(3);
      scl_m = 1'b0;
      wait_cyc(3);
    end
    wait_cyc(2);
    sda_m = ~give_ack; wait_cyc(2);
    scl_pulse();
    sda_m = 1'b1;
  endtask

  task automatic cpu_read(input int s);
    c_rd[s] = 1'b1; @(negedge clk); c_rd[s] = 1'b0; @(negedge clk);
  endtask

  task automatic cpu_clear(input int s);
    c_clr[s] = 1'b1; @(negedge clk); c_clr[s] = 1'b0; @(negedge clk);
  endtask

  task automatic cpu_load(input int s, input logic [7:0] d);
    wdat = d; c_wr[s] = 1'b1; @(negedge clk); c_wr[s] = 1'b0;
    c_rel[s] = 1'b1; @(negedge clk); c_rel[s] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] rb, s0, s1;
    scl_m = 1'b1; sda_m = 1'b1;
    c_rd = '0; c_wr = '0; c_rel = '0; c_clr = '0; c_sie = 2'b10; wdat = '0;
    rst_n = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);

    for (int s = 0; s < 2; s++) begin
      chk("R1", "status", stat[s], 8'h00);
      chk("R1", "irq", irq[s], 1'b0);
      chk("R1", "drives", {soe[s], coe[s]}, 2'b00);
    end

    // R2 start flag and start interrupt enable
    do_start();
    chk("R2", "u0 start bit", stat[0][3], 1'b1);
    chk("R2", "u1 start bit", stat[1][3], 1'b1);
    chk("R2", "u0 irq masked", irq[0], 1'b0);
    chk("R2", "u1 irq enabled", irq[1], 1'b1);
    do_stop();
    chk("R11", "u0 stop/start bits", {stat[0][4], stat[0][3]}, 2'b10);
    chk("R11", "u1 stop/start bits", {stat[1][4], stat[1][3]}, 2'b10);
    cpu_clear(1);

    // Master-write vectors: R3 address, R4 data, R5 buffer read
    for (int i = 0; i < 6; i++) begin
      int s;
      s = int'(VEC[i].sel);
      if (VEC[i].strt) begin
        do_start();
        cpu_clear(1);
      end
      send_byte(VEC[i].tx, ack);
      if (VEC[i].mst == 8'h09) begin
        chk("R3", "ack", ack, VEC[i].ack);
        chk("R3", "state", stat[s] & 8'h2D, VEC[i].mst);
        chk("R3", "buffer", bufd[s], VEC[i].tx);
        chk("R3", "irq", irq[s], 1'b1);
      end else begin
        chk("R4", "ack", ack, VEC[i].ack);
        chk("R4", "state", stat[s] & 8'h2D, VEC[i].mst);
        chk("R4", "buffer", bufd[s], VEC[i].tx);
        chk("R4", "irq", irq[s], 1'b1);
      end
      cpu_clear(s);
      cpu_read(s);
      chk("R5", "full cleared", stat[s][0], 1'b0);
    end
    do_stop();
    chk("R11", "u0 after writes", {stat[0][4], stat[0][3]}, 2'b10);

    // R10 address nobody owns
    do_start();
    cpu_clear(1);
    s0 = stat[0]; s1 = stat[1];
    send_byte(8'h7E, ack);
    chk("R10", "no ack", ack, 1'b0);
    chk("R10", "u0 status", stat[0], s0);
    chk("R10", "u1 status", stat[1], s1);
    chk("R10", "irqs", irq, 2'b00);
    do_stop();

    // Legacy read on u0: R6, R7, R8, R9
    do_start();
    send_byte(8'h31, ack);
    chk("R6", "legacy ack", ack, 1'b1);
    chk("R6", "legacy read state", stat[0] & 8'h2D, 8'h0C);
    chk("R6", "irq", irq[0], 1'b1);
    wait_cyc(20);
    chk("R7", "scl held", {coe[0], scl_bus}, 2'b10);
    cpu_clear(0);
    cpu_load(0, 8'hA5);
    recv_byte(1'b1, rb);
    chk("R7", "sent byte", rb, 8'hA5);
    chk("R8", "acked state", stat[0] & 8'h2D, 8'h2C);
    chk("R8", "irq", irq[0], 1'b1);
    chk("R8", "scl held again", coe[0], 1'b1);
    cpu_clear(0);
    cpu_load(0, 8'h3C);
    recv_byte(1'b0, rb);
    chk("R7", "second byte", rb, 8'h3C);
    chk("R9", "legacy nack state", stat[0] & 8'h2D, 8'h28);
    chk("R9", "no hold", coe[0], 1'b0);
    chk("R9", "irq", irq[0], 1'b1);
    do_stop();
    cpu_clear(0);

    // Newer read on u1
    do_start();
    send_byte(8'h61, ack);
    chk("R6", "newer ack", ack, 1'b1);
    chk("R6", "newer read state", stat[1] & 8'h2D, 8'h0D);
    chk("R6", "address in buffer", bufd[1], 8'h61);
    cpu_read(1);
    chk("R5", "newer full cleared", stat[1] & 8'h2D, 8'h0C);
    cpu_load(1, 8'h96);
    recv_byte(1'b1, rb);
    chk("R7", "newer sent byte", rb, 8'h96);
    chk("R8", "newer acked state", stat[1] & 8'h2D, 8'h2C);
    cpu_load(1, 8'h01);
    recv_byte(1'b0, rb);
    chk("R9", "newer nack state", stat[1] & 8'h2D, 8'h2C);
    chk("R9", "newer no hold", coe[1], 1'b0);
    do_stop();
    cpu_clear(1);

    // R12 overflow on u0
    do_start();
    send_byte(8'h30, ack);
    chk("R3", "overflow setup", stat[0] & 8'h2D, 8'h09);
    send_byte(8'h77, ack);
    chk("R12", "no ack", ack, 1'b0);
    chk("R12", "overflow bit", stat[0][6], 1'b1);
    chk("R12", "buffer kept", bufd[0], 8'h30);
    do_stop();

    // R13 sticky interrupt
    chk("R13", "irq set", irq[0], 1'b1);
    wait_cyc(30);
    chk("R13", "irq still set", irq[0], 1'b1);
    cpu_clear(0);
    chk("R13", "irq cleared", irq[0], 1'b0);

    summary();
    $finish;
  end
endmodule